// File: doc/BRIEF.md
# Multi-Channel Cell Framer with Chained CRC

This block gathers frames from several 64-bit streaming virtual-channel inputs and turns them into a single stream of tagged 64-bit words for a link sequencer. Each frame is cut into cells of at most `CELL_WORDS` data words. Every cell is bracketed by a leading control word and a trailing control word. The leading word names the channel, gives a per-channel cell sequence number and carries the local status field. The trailing word carries the byte count of the cell's final beat, a user byte and a running CRC-32. The CRC of a continuation cell starts from the CRC of the previous cell of the same frame.

A new cell is granted to the channels in round-robin order. The pick happens at every cell boundary, so long frames on different channels interleave cell by cell. A channel that the far end has paused is not given a new cell. A cell already under way still runs to its end. The link sequencer paces the block with a per-word grant. When it withholds the grant (for example, to insert its own words), nothing is consumed and the presented word stays put. The output word is presented in the same cycle it is formed. A word counts as transferred in a cycle where both `out_valid` and `out_grant` are high.

Top module: `cell_framer`

## Requirements
- R1: A leading control word is laid out as follows. Bits 63:56 are 0xAA for the first cell of a frame and 0xCC for any later cell. Bits 55:44 hold the channel's 12-bit cell number. Bits 43:40 hold the channel index. Bits 39:0 copy `link_status`.
- R2: A trailing control word is laid out as follows. Bits 63:56 are 0x55 when the cell ends its frame and 0x33 otherwise. Bits 55:24 hold the cell CRC. Bits 19:16 hold the number of set bits in the keep mask of the cell's final beat. Bits 7:0 hold that beat's user byte. Bits 23:20 and 15:8 are zero. Keep masks are contiguous from bit 0, so a mask encodes 0 to 8 valid bytes.
- R3: A cell carries at most `CELL_WORDS` (128) data words. A longer frame continues in further cells.
- R4: The CRC is computed over the data words of the cell only. It uses the reflected Ethernet polynomial 0xEDB88320, taking each word from bit 0 to bit 63, with no final inversion. The first cell of a frame starts from 0xFFFFFFFF. A later cell starts from the CRC sent in the previous cell of the same frame.
- R5: Each channel's cell number starts at 0 after reset. It rises by one per cell sent on that channel and wraps from 4095 to 0.
- R6: The next cell goes to the first channel, in cyclic order after the channel served last, whose input is valid and not paused. When no channel qualifies, `out_valid` is low between cells.
- R7: A channel whose `remote_pause` bit is high is never given a new cell. A cell already begun is completed regardless of that bit.
- R8: `in_ready` is high only for the channel of the cell in progress, only in its data phase, and only while `out_grant` is high. While `out_grant` is low, a presented trailing word stays unchanged.
- R9: After reset, `out_valid` and `in_ready` are low with no input valid. The first cell is served from channel 0 when all channels request.
- R10: `out_ctrl` is 1 on leading and trailing words and 0 on data words. Data words are passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_status | input | 40 | Local status field placed in leading words |
| remote_pause | input | NUM_CH | Far-end pause flag per channel |
| in_valid | input | NUM_CH | Input word valid per channel |
| in_ready | output | NUM_CH | Input word taken per channel |
| in_data | input | NUM_CH*64 | Input data, channel i in bits 64i+63:64i |
| in_keep | input | NUM_CH*8 | Byte keep mask per channel, meaningful on the last beat |
| in_last | input | NUM_CH | Last beat of frame per channel |
| in_user | input | NUM_CH*8 | User byte per channel |
| out_grant | input | 1 | Sequencer accepts the presented word this cycle |
| out_valid | output | 1 | A word is presented |
| out_ctrl | output | 1 | Presented word is a control word |
| out_data | output | 64 | Presented word |

## Verification
The assertions check the following on every cycle: that `in_ready` is one-hot and tied to the grant, that a trailing word is held while the grant is low, that a cell never exceeds its word limit, that a newly started cell never belongs to a paused or idle channel, and that each channel's cell number steps by exactly one per cell. The bench scenarios are what show the rest. They cover the exact bit layout of the control words and the chained CRC values over multi-cell frames. They show the round-robin order against the bench's own request pattern and the completion of a cell whose channel is paused mid-way. They also exercise the cell-number wrap after more than 4096 cells.

// File: rtl/cf_pkg.sv
`timescale 1ns/1ps
package cf_pkg;

  localparam logic [7:0] TAG_HEAD_FIRST = 8'hAA;
  localparam logic [7:0] TAG_HEAD_NEXT  = 8'hCC;
  localparam logic [7:0] TAG_TAIL_END   = 8'h55;
  localparam logic [7:0] TAG_TAIL_MORE  = 8'h33;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT      = 32'hFFFFFFFF;

  typedef enum logic [1:0] {
    PH_ARB  = 2'd0,
    PH_BODY = 2'd1,
    PH_TAIL = 2'd2
  } phase_e;

  function automatic logic [31:0] crc_fold64(input logic [31:0] seed,
                                             input logic [63:0] word);
    logic [31:0] c;
    logic        fb;
    c = seed;
    for (int b = 0; b < 64; b++) begin
      fb = c[0] ^ word[b];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_REFL;
    end
    return c;
  endfunction

endpackage

// File: rtl/cf_rr_arb.sv
`timescale 1ns/1ps
module cf_rr_arb #(
  parameter int N    = 4,
  parameter int CH_W = 2
) (
  input  logic [N-1:0]    req,
  input  logic [CH_W-1:0] last,
  output logic [CH_W-1:0] pick,
  output logic            any
);

  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int k = 1; k <= N; k++) begin
      if (!any && req[(int'(last) + k) % N]) begin
        any  = 1'b1;
        pick = CH_W'((int'(last) + k) % N);
      end
    end
  end

endmodule

// File: rtl/cf_crc_step.sv
`timescale 1ns/1ps
module cf_crc_step (
  input  logic [31:0] seed,
  input  logic [63:0] word,
  output logic [31:0] folded
);
  import cf_pkg::*;

  always_comb folded = crc_fold64(seed, word);

endmodule

// File: rtl/cf_chan_ctx.sv
`timescale 1ns/1ps
module cf_chan_ctx #(
  parameter int N     = 4,
  parameter int CH_W  = 2,
  parameter int PKT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [PKT_W-1:0] rd_pkt,
  output logic             rd_cont,
  output logic [31:0]      rd_crc,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic             wr_cont,
  input  logic [31:0]      wr_crc
);

  logic [PKT_W-1:0] pkt_q  [N];
  logic             cont_q [N];
  logic [31:0]      crc_q  [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        pkt_q[i]  <= '0;
        cont_q[i] <= 1'b0;
        crc_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (wr_en && (wr_ch == CH_W'(i))) begin
          pkt_q[i]  <= pkt_q[i] + 1'b1;
          cont_q[i] <= wr_cont;
          crc_q[i]  <= wr_crc;
        end
      end
    end
  end

  assign rd_pkt  = pkt_q[rd_ch];
  assign rd_cont = cont_q[rd_ch];
  assign rd_crc  = crc_q[rd_ch];

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R5: one cell closed on a channel moves its cell number by exactly one
    a_r5_pkt_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ch == CH_W'(g)) |=> (pkt_q[g] == $past(pkt_q[g]) + 1'b1));
    // R5: untouched channels keep their number
    a_r5_pkt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_ch == CH_W'(g)) |=> $stable(pkt_q[g]));
  end

endmodule

// File: rtl/cell_framer.sv
`timescale 1ns/1ps
module cell_framer #(
  parameter int NUM_CH     = 4,
  parameter int CELL_WORDS = 128,
  parameter int PKT_W      = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [39:0]           link_status,
  input  logic [NUM_CH-1:0]     remote_pause,
  input  logic [NUM_CH-1:0]     in_valid,
  output logic [NUM_CH-1:0]     in_ready,
  input  logic [NUM_CH*64-1:0]  in_data,
  input  logic [NUM_CH*8-1:0]   in_keep,
  input  logic [NUM_CH-1:0]     in_last,
  input  logic [NUM_CH*8-1:0]   in_user,
  input  logic                  out_grant,
  output logic                  out_valid,
  output logic                  out_ctrl,
  output logic [63:0]           out_data
);
  import cf_pkg::*;

  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int CNT_W = $clog2(CELL_WORDS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CELL_WORDS - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  // per-channel views of the flat input buses
  logic [63:0] data_a [NUM_CH];
  logic [7:0]  keep_a [NUM_CH];
  logic [7:0]  user_a [NUM_CH];
  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign data_a[g] = in_data[g*64 +: 64];
    assign keep_a[g] = in_keep[g*8 +: 8];
    assign user_a[g] = in_user[g*8 +: 8];
  end

  // state
  phase_e            phase_q, phase_n;
  logic [CH_W-1:0]   sel_q, sel_n;
  logic [CH_W-1:0]   prev_q, prev_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [31:0]       crc_q, crc_n;
  logic              eof_q, eof_n;
  logic [3:0]        nb_q, nb_n;
  logic [7:0]        usr_q, usr_n;

  // arbitration
  logic [NUM_CH-1:0] req;
  logic [CH_W-1:0]   pick;
  logic              any_req;
  assign req = in_valid & ~remote_pause;

  cf_rr_arb #(.N(NUM_CH), .CH_W(CH_W)) u_arb (
    .req  (req),
    .last (prev_q),
    .pick (pick),
    .any  (any_req)
  );

  // channel context
  logic [CH_W-1:0]  ctx_rd_ch;
  logic [PKT_W-1:0] ctx_pkt;
  logic             ctx_cont;
  logic [31:0]      ctx_crc;
  logic             ctx_wr;
  assign ctx_rd_ch = (phase_q == PH_ARB) ? pick : sel_q;

  cf_chan_ctx #(.N(NUM_CH), .CH_W(CH_W), .PKT_W(PKT_W)) u_ctx (
    .clk     (clk),
    .rst_n   (rst_ns),
    .rd_ch   (ctx_rd_ch),
    .rd_pkt  (ctx_pkt),
    .rd_cont (ctx_cont),
    .rd_crc  (ctx_crc),
    .wr_en   (ctx_wr),
    .wr_ch   (sel_q),
    .wr_cont (!eof_q),
    .wr_crc  (crc_q)
  );

  // crc datapath on the selected beat
  logic [63:0] beat_data;
  logic        beat_valid;
  logic        beat_last;
  logic        cell_full;
  logic [31:0] crc_fold;
  assign beat_data  = data_a[sel_q];
  assign beat_valid = in_valid[sel_q];
  assign beat_last  = in_last[sel_q];
  assign cell_full  = (cnt_q == CNT_LAST);

  cf_crc_step u_crc (
    .seed   (crc_q),
    .word   (beat_data),
    .folded (crc_fold)
  );

  // output word
  logic take;
  always_comb begin
    out_valid = 1'b0;
    out_ctrl  = 1'b0;
    out_data  = '0;
    unique case (phase_q)
      PH_ARB: begin
        out_valid = any_req;
        out_ctrl  = 1'b1;
        out_data  = {(ctx_cont ? TAG_HEAD_NEXT : TAG_HEAD_FIRST),
                     ctx_pkt, 4'(pick), link_status};
      end
      PH_BODY: begin
        out_valid = beat_valid;
        out_ctrl  = 1'b0;
        out_data  = beat_data;
      end
      PH_TAIL: begin
        out_valid = 1'b1;
        out_ctrl  = 1'b1;
        out_data  = {(eof_q ? TAG_TAIL_END : TAG_TAIL_MORE),
                     crc_q, 4'b0, nb_q, 8'b0, usr_q};
      end
      default: ;
    endcase
  end
  assign take = out_valid && out_grant;

  always_comb begin
    in_ready = '0;
    if (phase_q == PH_BODY && out_grant) in_ready[sel_q] = 1'b1;
  end

  assign ctx_wr = (phase_q == PH_TAIL) && take;

  // next state
  always_comb begin
    phase_n = phase_q;
    sel_n   = sel_q;
    prev_n  = prev_q;
    cnt_n   = cnt_q;
    crc_n   = crc_q;
    eof_n   = eof_q;
    nb_n    = nb_q;
    usr_n   = usr_q;
    if (take) begin
      unique case (phase_q)
        PH_ARB: begin
          phase_n = PH_BODY;
          sel_n   = pick;
          cnt_n   = '0;
          crc_n   = ctx_cont ? ctx_crc : CRC_INIT;
        end
        PH_BODY: begin
          crc_n = crc_fold;
          cnt_n = cnt_q + 1'b1;
          if (beat_last || cell_full) begin
            phase_n = PH_TAIL;
            eof_n   = beat_last;
            nb_n    = 4'($countones(keep_a[sel_q]));
            usr_n   = user_a[sel_q];
          end
        end
        PH_TAIL: begin
          phase_n = PH_ARB;
          prev_n  = sel_q;
        end
        default: phase_n = PH_ARB;
      endcase
    end
  end

  // registers, clock-enabled by take
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      phase_q <= PH_ARB;
      sel_q   <= '0;
      prev_q  <= CH_W'(NUM_CH - 1);
      cnt_q   <= '0;
      crc_q   <= '0;
      eof_q   <= 1'b0;
      nb_q    <= '0;
      usr_q   <= '0;
    end else if (take) begin
      phase_q <= phase_n;
      sel_q   <= sel_n;
      prev_q  <= prev_n;
      cnt_q   <= cnt_n;
      crc_q   <= crc_n;
      eof_q   <= eof_n;
      nb_q    <= nb_n;
      usr_q   <= usr_n;
    end
  end

  // checker: data words seen since the last leading word
  logic [CNT_W:0] seen_q;
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) seen_q <= '0;
    else if (take && phase_q == PH_ARB) seen_q <= '0;
    else if (take && !out_ctrl) seen_q <= seen_q + 1'b1;
  end

  // R3: never more data words in a cell than the limit
  a_r3_cell_bound: assert property (@(posedge clk) disable iff (!rst_ns)
    seen_q <= (CNT_W+1)'(CELL_WORDS));
  // R8: at most one channel is taken from, and only under grant
  a_r8_ready_onehot: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0(in_ready));
  a_r8_ready_grant: assert property (@(posedge clk) disable iff (!rst_ns)
    (|in_ready) |-> out_grant);
  // R8: a withheld trailing word does not change
  a_r8_tail_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (phase_q == PH_TAIL && !out_grant) |=> $stable(out_data));
  // R7: a new cell never starts on a paused channel
  a_r7_no_paused_start: assert property (@(posedge clk) disable iff (!rst_ns)
    (phase_q == PH_ARB && take) |-> !remote_pause[pick]);
  // R6: the chosen channel is actually asking
  a_r6_pick_valid: assert property (@(posedge clk) disable iff (!rst_ns)
    (phase_q == PH_ARB && take) |-> in_valid[pick]);

endmodule

// File: tb/cell_framer_test.sv
`timescale 1ns/1ps
module cell_framer_test;
  localparam int NCH = 4;
  localparam int CW  = 128;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [39:0]       link_status = '0;
  logic [NCH-1:0]    remote_pause = '0;
  logic [NCH-1:0]    in_valid = '0;
  logic [NCH-1:0]    in_ready;
  logic [NCH*64-1:0] in_data = '0;
  logic [NCH*8-1:0]  in_keep = '0;
  logic [NCH-1:0]    in_last = '0;
  logic [NCH*8-1:0]  in_user = '0;
  logic              out_grant = 1'b0;
  logic              out_valid;
  logic              out_ctrl;
  logic [63:0]       out_data;

  always #4 clk = ~clk;

  cell_framer #(.NUM_CH(NCH), .CELL_WORDS(CW), .PKT_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .link_status(link_status),
    .remote_pause(remote_pause), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_keep(in_keep), .in_last(in_last), .in_user(in_user),
    .out_grant(out_grant), .out_valid(out_valid), .out_ctrl(out_ctrl),
    .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit timeout = 0;

  // stimulus state
  int frames_left [NCH];
  int widx [NCH];
  int gpos [NCH];
  int cur_len [NCH];
  int cur_nb [NCH];
  int len_lo = 1, len_hi = 1, gap_pct = 0, pause_pct = 0, grant_pct = 100;
  logic [NCH-1:0] pause_force = '0;

  // monitor state
  int mph = 0;
  int cur_ch = 0;
  int cell_cnt = 0;
  int last_ch = NCH - 1;
  logic [31:0] mcrc;
  logic [11:0] epkt [NCH];
  bit          econt [NCH];
  logic [31:0] ecrc [NCH];
  bit          exp_eof;
  int          exp_nb;
  logic [7:0]  exp_user;
  bit          acc [NCH];
  bit          first_start = 1;
  bit          wrap_seen = 0;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] word_of(input int ch, input int pos);
    return {8'(ch), 24'(pos), (32'(pos) * 32'h9E3779B1) ^ (32'(ch) * 32'h01000193)};
  endfunction

  function automatic logic [7:0] user_of(input int ch, input int pos);
    return 8'(ch * 37 + pos * 3 + 1);
  endfunction

  function automatic logic [7:0] mask_of(input int nb);
    return (nb == 0) ? 8'h00 : 8'((16'h1 << nb) - 1);
  endfunction

  function automatic logic [31:0] crc_ref(input logic [31:0] c_in,
                                          input logic [63:0] w);
    logic [31:0] c;
    c = c_in;
    for (int i = 0; i < 64; i++) begin
      if (c[0] ^ w[i]) c = (c >> 1) ^ 32'hEDB88320;
      else             c = c >> 1;
    end
    return c;
  endfunction

  task automatic new_frame(input int ch);
    cur_len[ch] = len_lo + int'($urandom % (len_hi - len_lo + 1));
    cur_nb[ch]  = int'($urandom % 9);
    widx[ch]    = 0;
  endtask

  task automatic drive_inputs();
    for (int ch = 0; ch < NCH; ch++) begin
      bit lst;
      lst = (widx[ch] == cur_len[ch] - 1);
      in_data[ch*64 +: 64] = word_of(ch, gpos[ch]);
      in_last[ch]          = lst;
      in_keep[ch*8 +: 8]   = lst ? mask_of(cur_nb[ch]) : 8'hFF;
      in_user[ch*8 +: 8]   = user_of(ch, gpos[ch]);
      in_valid[ch]         = (frames_left[ch] > 0) && (int'($urandom % 100) >= gap_pct);
      remote_pause[ch]     = pause_force[ch] || (int'($urandom % 100) < pause_pct);
    end
    out_grant = (int'($urandom % 100) < grant_pct);
  endtask

  task automatic monitor();
    logic [NCH-1:0] exp_rdy;
    for (int ch = 0; ch < NCH; ch++) acc[ch] = 0;
    if (mph == 0) begin
      logic [NCH-1:0] rq;
      int exp_ch;
      rq = in_valid & ~remote_pause;
      chk(in_ready == '0, "R8 ready outside data phase", 64'(in_ready), 64'd0);
      chk(out_valid == (|rq), "R6 valid iff a channel qualifies", 64'(out_valid), 64'(|rq));
      if (out_valid && out_grant) begin
        int ch;
        exp_ch = -1;
        for (int k = 1; k <= NCH; k++)
          if (exp_ch < 0 && rq[(last_ch + k) % NCH]) exp_ch = (last_ch + k) % NCH;
        ch = int'(out_data[43:40]);
        chk(out_ctrl == 1'b1, "R10 leading word tag", 64'(out_ctrl), 64'd1);
        chk(ch == exp_ch, "R6 round-robin choice", 64'(ch), 64'(exp_ch));
        if (first_start) chk(ch == 0, "R9 first cell from channel 0", 64'(ch), 64'd0);
        first_start = 0;
        chk(!remote_pause[ch], "R7 paused channel started", 64'(remote_pause), 64'd0);
        chk(out_data[63:56] == (econt[ch] ? 8'hCC : 8'hAA), "R1 leading type",
            64'(out_data[63:56]), 64'(econt[ch] ? 8'hCC : 8'hAA));
        chk(out_data[39:0] == link_status, "R1 status field",
            64'(out_data[39:0]), 64'(link_status));
        chk(out_data[55:44] == epkt[ch], "R5 cell number",
            64'(out_data[55:44]), 64'(epkt[ch]));
        if (ch == 2 && epkt[ch] == 12'd0 && gpos[2] > 4000) wrap_seen = 1;
        cur_ch = ch;
        mcrc = econt[ch] ? ecrc[ch] : 32'hFFFFFFFF;
        cell_cnt = 0;
        mph = 1;
      end
    end else if (mph == 1) begin
      exp_rdy = out_grant ? (NCH'(1) << cur_ch) : '0;
      chk(in_ready == exp_rdy, "R8 ready pattern", 64'(in_ready), 64'(exp_rdy));
      if (out_valid && out_grant) begin
        logic [63:0] w;
        bit lastb;
        w = word_of(cur_ch, gpos[cur_ch]);
        chk(out_ctrl == 1'b0, "R10 data word tag", 64'(out_ctrl), 64'd0);
        chk(out_data == w, "R10 data passthrough", out_data, w);
        mcrc = crc_ref(mcrc, w);
        cell_cnt++;
        acc[cur_ch] = 1;
        lastb = (widx[cur_ch] == cur_len[cur_ch] - 1);
        if (lastb || cell_cnt == CW) begin
          exp_eof  = lastb;
          exp_nb   = lastb ? cur_nb[cur_ch] : 8;
          exp_user = user_of(cur_ch, gpos[cur_ch]);
          mph = 2;
        end
      end
    end else begin
      chk(in_ready == '0, "R8 ready in trailing phase", 64'(in_ready), 64'd0);
      if (out_valid && out_grant) begin
        chk(out_ctrl == 1'b1, "R3 cell closes after limit or last", 64'(out_ctrl), 64'd1);
        chk(out_data[63:56] == (exp_eof ? 8'h55 : 8'h33), "R2 trailing type",
            64'(out_data[63:56]), 64'(exp_eof ? 8'h55 : 8'h33));
        chk(out_data[55:24] == mcrc, "R4 cell crc", 64'(out_data[55:24]), 64'(mcrc));
        chk(int'(out_data[19:16]) == exp_nb, "R2 byte count",
            64'(out_data[19:16]), 64'(exp_nb));
        chk(out_data[7:0] == exp_user, "R2 user byte", 64'(out_data[7:0]), 64'(exp_user));
        chk(out_data[23:20] == 4'd0 && out_data[15:8] == 8'd0, "R2 zero fields",
            out_data, 64'd0);
        ecrc[cur_ch]  = mcrc;
        econt[cur_ch] = !exp_eof;
        epkt[cur_ch]  = epkt[cur_ch] + 12'd1;
        last_ch = cur_ch;
        mph = 0;
      end
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    if (rst_n) monitor();
    @(posedge clk);
    #1;
    for (int ch = 0; ch < NCH; ch++) begin
      if (acc[ch]) begin
        gpos[ch]++;
        widx[ch]++;
        if (widx[ch] == cur_len[ch]) begin
          frames_left[ch]--;
          new_frame(ch);
        end
      end
    end
    drive_inputs();
    cycles++;
    if (cycles > 190000 && !timeout) begin
      timeout = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n && !timeout; i++) cycle();
  endtask

  function automatic bit busy();
    bit b;
    b = (mph != 0);
    for (int ch = 0; ch < NCH; ch++) if (frames_left[ch] > 0) b = 1;
    return b;
  endfunction

  task automatic run_done();
    while (!timeout && busy()) cycle();
  endtask

  task automatic load(input int ch, input int n);
    frames_left[ch] = n;
    new_frame(ch);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int ch = 0; ch < NCH; ch++) begin
      frames_left[ch] = 0; widx[ch] = 0; gpos[ch] = 0; cur_len[ch] = 1; cur_nb[ch] = 8;
      epkt[ch] = '0; econt[ch] = 0; ecrc[ch] = '0;
    end
    link_status = 40'h5A_1234_ABCD;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    run_cycles(6);
    // R9: idle after reset
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 reset out_valid", 64'(out_valid), 64'd0);
    chk(in_ready == '0, "R9 reset in_ready", 64'(in_ready), 64'd0);

    // all channels, one frame each of 130 words: interleave and split (R3, R6)
    len_lo = 130; len_hi = 130;
    for (int ch = 0; ch < NCH; ch++) load(ch, 1);
    run_done();

    // single channel, 300-word frame: SOF, SOC, SOC, EOF and crc chain (R1, R4)
    link_status = 40'h00_FFFF_0001;
    len_lo = 300; len_hi = 300;
    load(1, 1);
    run_done();

    // R7: paused channel is not started while others finish
    len_lo = 5; len_hi = 5;
    pause_force = 4'b0010;
    for (int ch = 0; ch < NCH; ch++) load(ch, 1);
    run_cycles(200);
    chk(frames_left[1] == 1, "R7 paused channel left waiting", 64'(frames_left[1]), 64'd1);
    chk(frames_left[0] + frames_left[2] + frames_left[3] == 0, "R7 others served",
        64'(frames_left[0] + frames_left[2] + frames_left[3]), 64'd0);
    pause_force = '0;
    run_done();

    // R7: pause raised mid-cell, the cell still completes
    len_lo = 50; len_hi = 50;
    load(0, 1);
    run_cycles(15);
    pause_force = 4'b0001;
    run_cycles(100);
    chk(frames_left[0] == 0, "R7 in-progress cell completes", 64'(frames_left[0]), 64'd0);
    chk(mph == 0, "R7 cell closed under pause", 64'(mph), 64'd0);
    pause_force = '0;

    // random traffic with grant gaps, input gaps and pauses (R2, R4, R6, R8)
    len_lo = 1; len_hi = 300;
    gap_pct = 10; pause_pct = 15; grant_pct = 75;
    link_status = 40'hC3_0F0F_7777;
    for (int ch = 0; ch < NCH; ch++) load(ch, 30);
    run_done();

    // R5: cell-number wrap on channel 2
    gap_pct = 0; pause_pct = 0; grant_pct = 100;
    len_lo = 1; len_hi = 1;
    load(2, 4200);
    run_done();
    chk(wrap_seen, "R5 cell number wraps to 0", 64'(wrap_seen), 64'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule